// File: doc/BRIEF.md
# Masked Burst Address Counter

This block produces the address for one port of a burst-capable memory. The address can be loaded from the port's address inputs, cleared, or stepped forward one location per clock. A mask register selects which low address bits take part in counting. The bits above the mask hold their value, so a burst stays inside an aligned window whose size is a power of two.

Every address load also records the value in a mirror register. When the counting field is already all ones, the next step wraps. A wrap either clears the counting field or returns the whole address to the mirror, and the wrap select input chooses which. A retransmit control also returns the address to the mirror at any time. An active-low flag pulses for one cycle when a step brings the counting field to all ones. This tells the port that the end of the window has been reached.

The mask is loaded through the same load and clear controls, with the select input steering them away from the counter. The mask, the mirror and the address are all readable at the outputs.

Top module: `burst_addr_counter`

## Requirements
- R1: After reset the address and the mirror are zero, the mask is all ones and `cnt_int_n` is high.
- R2: When `ld_stb` is high, `cnt_clr` is low and `mask_sel` is low, the address and the mirror both take `addr_in` at the clock edge.
- R3: When `cnt_clr` is high and `mask_sel` is low, the address becomes zero. This happens even if `ld_stb` is also high, and the mirror is left unchanged.
- R4: When `ld_stb` is high, `cnt_clr` is low and `mask_sel` is high, the mask takes the unbroken run of ones at the bottom of `addr_in`. Bit i of the mask is the AND of `addr_in` bits 0 through i. The address and the mirror are left unchanged.
- R5: When `cnt_clr` is high and `mask_sel` is high, the mask becomes all ones and the address is left unchanged.
- R6: A step happens when `cnt_en` is high, `mask_sel` is low and no clear, load or retransmit is asserted. If the counting field (address AND mask) is not all ones, a step adds one to the counting field and leaves the bits outside the mask unchanged.
- R7: A step taken when the counting field is all ones, with `wrap_mirror` low, clears the counting field and leaves the other bits unchanged.
- R8: A step taken when the counting field is all ones, with `wrap_mirror` high, loads the whole address from the mirror.
- R9: `retx` loads the address from the mirror. A clear or load that acts in the same cycle takes priority over it, and it takes priority over a step. It acts whatever the value of `mask_sel`.
- R10: `cnt_int_n` goes low for exactly the one cycle after a step that brings the counting field to all ones without wrapping. At every other time it is high.
- R11: When `mask_sel` is high, `cnt_en` has no effect on the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_in | input | AW | Address or mask value to load |
| ld_stb | input | 1 | Load strobe, steered to the counter or the mask by `mask_sel` |
| cnt_en | input | 1 | Step enable |
| cnt_clr | input | 1 | Clear, steered to the counter or the mask by `mask_sel` |
| mask_sel | input | 1 | 0: clear and load act on the counter; 1: they act on the mask |
| wrap_mirror | input | 1 | Wrap mode: 0 clears the counting field, 1 reloads from the mirror |
| retx | input | 1 | Return the address to the mirror |
| addr_out | output | AW | Current address |
| cnt_int_n | output | 1 | Active-low one-cycle flag: counting field reached all ones |
| mask_out | output | AW | Mask readback |
| mirror_out | output | AW | Mirror readback |

## Verification
The bench builds the block with a 6-bit address. At that width all 64 possible mask load values can be applied, and every one of the seven contiguous mask widths can be checked. For each mask width, in both wrap modes, the bench steps the counter through more than one full window. This exercises every increment, the interrupt pulse, and the wrap with the high bits held. The priority combinations of clear, load, retransmit and step are driven directly, and their expected values come from an arithmetic model in the bench.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;

   typedef enum logic [2:0] {
      OP_IDLE,
      OP_CLR,
      OP_LOAD,
      OP_RETX,
      OP_INC
   } ctr_op_e;

   // Fixed priority: clear, load, retransmit, step.
   function automatic ctr_op_e pick_op(input logic clr, input logic ld,
                                       input logic rt, input logic en);
      if (clr)     return OP_CLR;
      else if (ld) return OP_LOAD;
      else if (rt) return OP_RETX;
      else if (en) return OP_INC;
      else         return OP_IDLE;
   endfunction

endpackage

// File: rtl/burst_ctr_mask.sv
module burst_ctr_mask
   import burst_ctr_pkg::*;
#(
   parameter int AW = 19
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ctr_op_e       op,
   input  logic          sel,
   input  logic [AW-1:0] val,
   output logic [AW-1:0] mask_q
);

   // Prefix AND keeps only the unbroken run of ones from bit 0.
   logic [AW-1:0] run;

   assign run[0] = val[0];
   for (genvar i = 1; i < AW; i++) begin : g_run
      assign run[i] = run[i-1] & val[i];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mask_q <= '1;
      end else if (sel) begin
         if (op == OP_CLR)       mask_q <= '1;
         else if (op == OP_LOAD) mask_q <= run;
      end
   end

endmodule

// File: rtl/burst_ctr_step.sv
module burst_ctr_step #(
   parameter int AW              = 19,
   parameter bit HAS_MIRROR_WRAP = 1'b1
) (
   input  logic [AW-1:0] cur,
   input  logic [AW-1:0] mask,
   input  logic [AW-1:0] mirror,
   input  logic          wrap_mirror,
   output logic [AW-1:0] nxt,
   output logic          hit
);

   logic [AW-1:0] field;
   logic [AW-1:0] bumped;
   logic [AW-1:0] fixed_bits;
   logic          at_top;
   logic [AW-1:0] wrap_val;

   assign field      = cur & mask;
   assign at_top     = (field == mask);
   assign bumped     = (cur + 1'b1) & mask;
   assign fixed_bits = cur & ~mask;

   if (HAS_MIRROR_WRAP) begin : g_mirror_wrap
      assign wrap_val = wrap_mirror ? mirror : fixed_bits;
   end else begin : g_zero_wrap
      logic unused_wrap;
      assign unused_wrap = wrap_mirror ^ (^mirror);
      assign wrap_val    = fixed_bits;
   end

   assign nxt = at_top ? wrap_val : (fixed_bits | bumped);
   assign hit = !at_top && (bumped == mask);

endmodule

// File: rtl/burst_addr_counter.sv
module burst_addr_counter
   import burst_ctr_pkg::*;
#(
   parameter int AW              = 19,
   parameter bit HAS_MIRROR_WRAP = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [AW-1:0] addr_in,
   input  logic          ld_stb,
   input  logic          cnt_en,
   input  logic          cnt_clr,
   input  logic          mask_sel,
   input  logic          wrap_mirror,
   input  logic          retx,
   output logic [AW-1:0] addr_out,
   output logic          cnt_int_n,
   output logic [AW-1:0] mask_out,
   output logic [AW-1:0] mirror_out
);

   if (AW < 2 || AW > 32) begin : g_bad_width
      $error("burst_addr_counter: AW must lie in 2..32");
   end

   ctr_op_e       op;
   logic [AW-1:0] cnt_q;
   logic [AW-1:0] mir_q;
   logic [AW-1:0] mask_q;
   logic [AW-1:0] step_nxt;
   logic          step_hit;
   logic          int_q;

   assign op = pick_op(cnt_clr, ld_stb, retx, cnt_en);

   burst_ctr_mask #(.AW(AW)) i_mask (
      .clk    (clk),
      .rst_n  (rst_n),
      .op     (op),
      .sel    (mask_sel),
      .val    (addr_in),
      .mask_q (mask_q)
   );

   burst_ctr_step #(.AW(AW), .HAS_MIRROR_WRAP(HAS_MIRROR_WRAP)) i_step (
      .cur         (cnt_q),
      .mask        (mask_q),
      .mirror      (mir_q),
      .wrap_mirror (wrap_mirror),
      .nxt         (step_nxt),
      .hit         (step_hit)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         mir_q <= '0;
         int_q <= 1'b1;
      end else begin
         int_q <= 1'b1;
         unique case (op)
            OP_CLR:  if (!mask_sel) cnt_q <= '0;
            OP_LOAD: if (!mask_sel) begin
                        cnt_q <= addr_in;
                        mir_q <= addr_in;
                     end
            OP_RETX: cnt_q <= mir_q;
            OP_INC:  if (!mask_sel) begin
                        cnt_q <= step_nxt;
                        int_q <= !step_hit;
                     end
            default: ;
         endcase
      end
   end

   assign addr_out   = cnt_q;
   assign mirror_out = mir_q;
   assign mask_out   = mask_q;
   assign cnt_int_n  = int_q;

endmodule

// File: rtl/burst_ctr_checker.sv
module burst_ctr_checker #(
   parameter int AW = 19
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] addr_in,
   input logic          ld_stb,
   input logic          cnt_en,
   input logic          cnt_clr,
   input logic          mask_sel,
   input logic          wrap_mirror,
   input logic          retx,
   input logic [AW-1:0] addr_out,
   input logic          cnt_int_n,
   input logic [AW-1:0] mask_out,
   input logic [AW-1:0] mirror_out
);

   logic step_now;
   assign step_now = cnt_en && !cnt_clr && !ld_stb && !retx && !mask_sel;

   p_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (ld_stb && !cnt_clr && !mask_sel) |=>
         (addr_out == $past(addr_in)) && (mirror_out == $past(addr_in)));

   p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && !mask_sel) |=> (addr_out == '0) && $stable(mirror_out));

   p_mask_contig_r4: assert property (@(posedge clk) disable iff (!rst_n)
      ((mask_out + 1'b1) & mask_out) == '0);

   p_mask_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_clr && mask_sel) |=> (mask_out == '1) && $stable(addr_out));

   p_high_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (step_now && ((addr_out & mask_out) != mask_out)) |=>
         ((addr_out & ~mask_out) == $past(addr_out & ~mask_out)));

   p_mirror_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (step_now && wrap_mirror && ((addr_out & mask_out) == mask_out)) |=>
         (addr_out == $past(mirror_out)));

   p_retx_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (retx && !cnt_clr && !ld_stb) |=> (addr_out == $past(mirror_out)));

   p_int_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_int_n |=> cnt_int_n);

   p_int_ones_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !cnt_int_n |-> ((addr_out & mask_out) == mask_out));

   p_sel_noinc_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_sel && cnt_en && !cnt_clr && !ld_stb && !retx) |=>
         $stable(addr_out));

endmodule

bind burst_addr_counter burst_ctr_checker #(.AW(AW)) i_chk (.*);

// File: tb/test_burst_addr_counter.sv
module test_burst_addr_counter;

   localparam int AW = 6;
   localparam logic [AW-1:0] ALL1 = '1;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [AW-1:0] addr_in = '0;
   logic          ld_stb = 1'b0, cnt_en = 1'b0, cnt_clr = 1'b0;
   logic          mask_sel = 1'b0, wrap_mirror = 1'b0, retx = 1'b0;
   logic [AW-1:0] addr_out, mask_out, mirror_out;
   logic          cnt_int_n;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // bench model
   logic [AW-1:0] m_cnt = '0, m_mir = '0, m_mask = '1;
   logic          m_int = 1'b1;

   always #4 clk = ~clk;

   burst_addr_counter #(.AW(AW)) i_burst_addr_counter (
      .clk(clk), .rst_n(rst_n), .addr_in(addr_in), .ld_stb(ld_stb),
      .cnt_en(cnt_en), .cnt_clr(cnt_clr), .mask_sel(mask_sel),
      .wrap_mirror(wrap_mirror), .retx(retx), .addr_out(addr_out),
      .cnt_int_n(cnt_int_n), .mask_out(mask_out), .mirror_out(mirror_out)
   );

   task automatic chk(input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic chk_all(input string req);
      chk(req, "addr", int'(addr_out), int'(m_cnt));
      chk(req, "mirror", int'(mirror_out), int'(m_mir));
      chk(req, "mask", int'(mask_out), int'(m_mask));
      chk("R10", "int_n", int'(cnt_int_n), int'(m_int));
   endtask

   // Apply one cycle of controls, update the model, then compare.
   task automatic do_op(input string req, input bit clr, input bit ld,
                        input bit rt, input bit en, input bit sel,
                        input bit wm, input logic [AW-1:0] a);
      logic [AW-1:0] fld, nf, run;
      cnt_clr = clr; ld_stb = ld; retx = rt; cnt_en = en;
      mask_sel = sel; wrap_mirror = wm; addr_in = a;
      m_int = 1'b1;
      if (clr) begin
         if (sel) m_mask = '1; else m_cnt = '0;
      end else if (ld) begin
         if (sel) begin
            run = '0;
            for (int i = 0; i < AW; i++) begin
               if (a[i] && (i == 0 || run[i-1])) run[i] = 1'b1;
            end
            m_mask = run;
         end else begin
            m_cnt = a; m_mir = a;
         end
      end else if (rt) begin
         m_cnt = m_mir;
      end else if (en && !sel) begin
         fld = m_cnt & m_mask;
         if (fld == m_mask) begin
            m_cnt = wm ? m_mir : (m_cnt & ~m_mask);
         end else begin
            nf = fld + 1'b1;
            m_cnt = (m_cnt & ~m_mask) | nf;
            if (nf == m_mask) m_int = 1'b0;
         end
      end
      @(posedge clk);
      #2;
      cnt_clr = 0; ld_stb = 0; retx = 0; cnt_en = 0; mask_sel = 0;
      chk_all(req);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      #2;
      chk_all("R1");
      rst_n = 1'b1;
      @(posedge clk); #2;
      chk_all("R1");

      do_op("R2", 0, 1, 0, 0, 0, 0, 6'h2A);
      do_op("R3", 1, 1, 0, 0, 0, 0, 6'h15);
      do_op("R2", 0, 1, 0, 0, 0, 0, 6'h13);

      // Every mask load value; counter and mirror must not move.
      for (int v = 0; v < 64; v++)
         do_op("R4", 0, 1, 0, 0, 1, 0, AW'(v));
      do_op("R5", 1, 1, 0, 0, 1, 0, 6'h00);

      // Every mask width, both wrap modes, more than one full window.
      for (int k = 0; k <= AW; k++) begin
         for (int w = 0; w < 2; w++) begin
            logic [AW-1:0] mk;
            mk = AW'((1 << k) - 1);
            do_op("R4", 0, 1, 0, 0, 1, 0, mk);
            do_op("R2", 0, 1, 0, 0, 0, 0, 6'b101101 ^ AW'(w * 3));
            for (int s = 0; s < (1 << k) + 3; s++) begin
               if ((m_cnt & m_mask) != m_mask)
                  do_op("R6", 0, 0, 0, 1, 0, w[0], '0);
               else if (w == 0)
                  do_op("R7", 0, 0, 0, 1, 0, 1'b0, '0);
               else
                  do_op("R8", 0, 0, 0, 1, 0, 1'b1, '0);
            end
         end
      end

      // Retransmit and its priority.
      do_op("R5", 1, 0, 0, 0, 1, 0, '0);
      do_op("R2", 0, 1, 0, 0, 0, 0, 6'h05);
      do_op("R6", 0, 0, 0, 1, 0, 0, '0);
      do_op("R6", 0, 0, 0, 1, 0, 0, '0);
      do_op("R9", 0, 0, 1, 1, 0, 0, '0);
      do_op("R9", 0, 1, 1, 0, 0, 0, 6'h31);
      do_op("R6", 0, 0, 0, 1, 0, 0, '0);
      do_op("R9", 0, 0, 1, 0, 1, 0, '0);
      do_op("R9", 1, 0, 1, 0, 0, 0, '0);

      // Step with mask select high changes nothing.
      do_op("R2", 0, 1, 0, 0, 0, 0, 6'h0E);
      do_op("R11", 0, 0, 0, 1, 1, 0, '0);
      do_op("R11", 0, 0, 0, 1, 1, 1, '0);
      do_op("R6", 0, 0, 0, 1, 0, 0, '0);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule